// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block drives four independent pulse-width-modulated outputs from a single source clock. Each channel has its own bank of registers on a simple single-cycle read/write bus. A channel divides the source clock by a prescale count, then walks a step counter through a modulus. Its output is high while the step index is below the duty value. One output period therefore spans (prescale+1)·modulus source cycles, and the high part spans (prescale+1)·duty cycles.

Software first writes the modulus and duty shadow registers, which leaves the waveform untouched. Writing the prescale register then commits prescale, modulus and duty together as one update. On a running channel the committed set waits for the current period to end, so no period is ever a mix of old and new settings. On an idle channel it takes effect at once. Divider and the two pattern words are storage only.

Top module: `pwm_bank_ctrl`

## Requirements
- R1: Channel c's registers sit at byte address c·0x20 + offset, with offsets 0x00 prescale, 0x04 modulus, 0x08 duty, 0x0C divider, 0x10 pattern low, 0x14 pattern high and 0x18 enable. A read returns the last value written to that channel's register, and the banks do not affect one another.
- R2: Prescale, duty, divider and both pattern words keep bits 15:0 of the written data. Modulus keeps bits 7:0. Enable keeps bit 0. All other bits read as zero.
- R3: Offsets 0x1C to 0x1F and all offsets that are not a multiple of four read as zero. Writes to them change no register.
- R4: With 0 < duty < modulus, an enabled channel's output is high for (prescale+1)·duty cycles and low for (prescale+1)·(modulus−duty) cycles in every period.
- R5: Writes to modulus or duty alone do not alter the running waveform.
- R6: A prescale write commits the shadow prescale, modulus and duty as one set. On a running channel the period in progress completes with the old set, and the next period uses the new set.
- R7: An active modulus of zero holds the output low.
- R8: An active duty greater than or equal to a non-zero active modulus holds the output high while the channel is enabled.
- R9: Clearing enable drives the output low from the next cycle. Setting it again starts a fresh period that begins with a full high phase.
- R10: After reset, all outputs are low and every register reads zero.
- R11: The four channels run different settings at the same time without affecting one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock, also the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per access |
| bus_rd_en | input | 1 | Read strobe; data appears on bus_rdata the following cycle |
| bus_addr | input | 7 | Byte address: channel index in bits 6:5, register offset in 4:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 4 | One waveform output per channel |

## Verification
The bus properties assume that the strobes and address are stable across the sampling edge, and that a strobe lasts exactly one cycle per access. The bench drives every bus signal on the falling edge and lowers it after one rising edge, with an idle cycle between accesses. The output properties assume that the channel counters restart from zero whenever a new set is applied or enable rises. They also assume that enable never toggles in the same cycle as a prescale commit. The stimulus always spaces those two writes apart and waits well past a period boundary before it judges the new waveform.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
package pwm_bank_pkg;

    localparam int DATA_W     = 32;
    localparam int SCALE_W    = 16;
    localparam int MOD_W      = 8;
    localparam int DUTY_W     = 16;
    localparam int AUX_W      = 16;
    localparam int BANK_SHIFT = 5;
    localparam int OFF_W      = BANK_SHIFT;

    // Register offsets inside a channel bank; the addressing depends on them.
    typedef enum logic [OFF_W-1:0] {
        OFF_SCALE = 5'h00,
        OFF_MOD   = 5'h04,
        OFF_DUTY  = 5'h08,
        OFF_DIV   = 5'h0C,
        OFF_PATL  = 5'h10,
        OFF_PATH  = 5'h14,
        OFF_RUN   = 5'h18
    } reg_off_e;

    // Waveform set that is committed as one unit.
    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic [MOD_W-1:0]   modv;
        logic [DUTY_W-1:0]  duty;
    } wave_cfg_t;

    // Full shadow bank of one channel.
    typedef struct packed {
        wave_cfg_t          cfg;
        logic [AUX_W-1:0]   div;
        logic [AUX_W-1:0]   pat_lo;
        logic [AUX_W-1:0]   pat_hi;
        logic               run;
    } bank_regs_t;

    function automatic logic [DATA_W-1:0] read_word(bank_regs_t r, logic [OFF_W-1:0] off);
        logic [DATA_W-1:0] v;
        v = '0;
        case (off)
            OFF_SCALE: v = DATA_W'(r.cfg.scale);
            OFF_MOD:   v = DATA_W'(r.cfg.modv);
            OFF_DUTY:  v = DATA_W'(r.cfg.duty);
            OFF_DIV:   v = DATA_W'(r.div);
            OFF_PATL:  v = DATA_W'(r.pat_lo);
            OFF_PATH:  v = DATA_W'(r.pat_hi);
            OFF_RUN:   v = DATA_W'(r.run);
            default:   v = '0;
        endcase
        return v;
    endfunction

    function automatic bank_regs_t write_word(bank_regs_t r, logic [OFF_W-1:0] off,
                                              logic [DATA_W-1:0] d);
        bank_regs_t n;
        n = r;
        case (off)
            OFF_SCALE: n.cfg.scale = d[SCALE_W-1:0];
            OFF_MOD:   n.cfg.modv  = d[MOD_W-1:0];
            OFF_DUTY:  n.cfg.duty  = d[DUTY_W-1:0];
            OFF_DIV:   n.div       = d[AUX_W-1:0];
            OFF_PATL:  n.pat_lo    = d[AUX_W-1:0];
            OFF_PATH:  n.pat_hi    = d[AUX_W-1:0];
            OFF_RUN:   n.run       = d[0];
            default:   n = r;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
`timescale 1ns/1ps
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output bank_regs_t        regs_o [NUM_CH],
    output logic [NUM_CH-1:0] commit_o
);

    localparam int CH_W = ADDR_W - BANK_SHIFT;

    logic [CH_W-1:0]  ch_idx;
    logic [OFF_W-1:0] off;
    logic             hit;

    assign ch_idx = addr[ADDR_W-1:BANK_SHIFT];
    assign off    = addr[BANK_SHIFT-1:0];
    assign hit    = (32'(ch_idx) < NUM_CH);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_bank
        bank_regs_t regs_q;
        logic       commit_q;
        logic       sel;

        assign sel = hit && (ch_idx == CH_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q   <= '0;
                commit_q <= 1'b0;
            end else begin
                // The commit pulse lines up with the updated shadow prescale.
                commit_q <= wr_en && sel && (off == OFF_SCALE);
                if (wr_en && sel) begin
                    regs_q <= write_word(regs_q, off, wdata);
                end
            end
        end

        assign regs_o[g]   = regs_q;
        assign commit_o[g] = commit_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= hit ? read_word(regs_o[ch_idx], off) : '0;
        end
    end

endmodule

// File: rtl/pwm_wave_chan.sv
`timescale 1ns/1ps
module pwm_wave_chan
    import pwm_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wave_cfg_t cfg_i,
    input  logic      run_i,
    input  logic      commit_i,
    output logic      pwm_o,
    output wave_cfg_t act_o
);

    wave_cfg_t          act_q;
    wave_cfg_t          staged_q;
    logic               pend_q;
    logic [SCALE_W-1:0] pre_q;
    logic [MOD_W-1:0]   step_q;

    logic      idle;
    logic      pre_wrap;
    logic      last_tick;
    logic      have_upd;
    logic      apply;
    wave_cfg_t src;

    assign idle      = !run_i || (act_q.modv == '0);
    assign pre_wrap  = (pre_q == act_q.scale);
    assign last_tick = pre_wrap && (step_q == (act_q.modv - MOD_W'(1)));
    assign have_upd  = commit_i || pend_q;
    assign src       = commit_i ? cfg_i : staged_q;
    // An idle channel takes the new set at once; a running one waits for the period end.
    assign apply     = have_upd && (idle || last_tick);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= '0;
            staged_q <= '0;
            pend_q   <= 1'b0;
        end else if (apply) begin
            act_q  <= src;
            pend_q <= 1'b0;
        end else if (commit_i) begin
            staged_q <= cfg_i;
            pend_q   <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i || apply || (act_q.modv == '0)) begin
            pre_q  <= '0;
            step_q <= '0;
        end else if (pre_wrap) begin
            pre_q  <= '0;
            step_q <= last_tick ? '0 : step_q + MOD_W'(1);
        end else begin
            pre_q <= pre_q + SCALE_W'(1);
        end
    end

    assign pwm_o = run_i && (act_q.modv != '0) && (DUTY_W'(step_q) < act_q.duty);
    assign act_o = act_q;

endmodule

// File: rtl/pwm_bank_ctrl.sv
`timescale 1ns/1ps
module pwm_bank_ctrl
    import pwm_bank_pkg::*;
#(
    parameter int   NUM_CH = 4,
    localparam int  ADDR_W = BANK_SHIFT + $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    bank_regs_t               regs [NUM_CH];
    logic [NUM_CH-1:0]        commit;
    logic [NUM_CH-1:0]        run_vec;
    logic [NUM_CH*MOD_W-1:0]  act_mod_flat;
    logic [NUM_CH*DUTY_W-1:0] act_duty_flat;

    pwm_bank_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr_en),
        .rd_en    (bus_rd_en),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .regs_o   (regs),
        .commit_o (commit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        wave_cfg_t act;

        pwm_wave_chan chan_i (
            .clk      (clk),
            .rst      (rst),
            .cfg_i    (regs[g].cfg),
            .run_i    (regs[g].run),
            .commit_i (commit[g]),
            .pwm_o    (pwm_out[g]),
            .act_o    (act)
        );

        assign run_vec[g]                          = regs[g].run;
        assign act_mod_flat[g*MOD_W +: MOD_W]      = act.modv;
        assign act_duty_flat[g*DUTY_W +: DUTY_W]   = act.duty;
    end

endmodule

// File: rtl/pwm_bank_chk.sv
`timescale 1ns/1ps
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 7
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_wr_en,
    input logic                     bus_rd_en,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [DATA_W-1:0]        bus_wdata,
    input logic [DATA_W-1:0]        bus_rdata,
    input logic [NUM_CH-1:0]        pwm_out,
    input logic [NUM_CH-1:0]        run_vec,
    input logic [NUM_CH*MOD_W-1:0]  act_mod_flat,
    input logic [NUM_CH*DUTY_W-1:0] act_duty_flat
);

    // R3
    unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && (bus_addr[4:2] == 3'b111)) |=> (bus_rdata == '0));

    // R2
    mod_width_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && (bus_addr[BANK_SHIFT-1:0] == OFF_MOD)) |=> (bus_rdata[DATA_W-1:MOD_W] == '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] RUN_ADDR = ADDR_W'((g << BANK_SHIFT) + int'(OFF_RUN));

        // R9
        run_off_low_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_wr_en && (bus_addr == RUN_ADDR) && !bus_wdata[0]) |=> !pwm_out[g]);

        // R7
        idle_low_chk: assert property (@(posedge clk) disable iff (rst)
            (act_mod_flat[g*MOD_W +: MOD_W] == '0) |-> !pwm_out[g]);

        // R8
        full_high_chk: assert property (@(posedge clk) disable iff (rst)
            (run_vec[g] && (act_mod_flat[g*MOD_W +: MOD_W] != '0) &&
             (act_duty_flat[g*DUTY_W +: DUTY_W] >= DUTY_W'(act_mod_flat[g*MOD_W +: MOD_W])))
            |-> pwm_out[g]);
    end

endmodule

bind pwm_bank_ctrl pwm_bank_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .bus_wr_en     (bus_wr_en),
    .bus_rd_en     (bus_rd_en),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .pwm_out       (pwm_out),
    .run_vec       (run_vec),
    .act_mod_flat  (act_mod_flat),
    .act_duty_flat (act_duty_flat)
);

// File: tb/pwm_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwm_bank_ctrl_tb_top;

    localparam int NCH = 4;
    localparam int AW  = 7;
    localparam logic [4:0] O_SCALE = 5'h00, O_MOD = 5'h04, O_DUTY = 5'h08, O_DIV = 5'h0C,
                           O_PATL = 5'h10, O_PATH = 5'h14, O_RUN = 5'h18, O_HOLE = 5'h1C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr_en = 1'b0;
    logic          bus_rd_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NCH-1:0] pwm_out;

    int n_chk = 0;
    int n_err = 0;

    int   rises   [NCH];
    int   last_hi [NCH];
    int   last_lo [NCH];
    int   runlen  [NCH];
    logic prev    [NCH];

    always #4 clk = ~clk;

    pwm_bank_ctrl #(.NUM_CH(NCH)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // Run-length monitor, sampled on the falling edge.
    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (rst) begin
                rises[c] = 0; last_hi[c] = 0; last_lo[c] = 0; runlen[c] = 0; prev[c] = 1'b0;
            end else if (pwm_out[c] == prev[c]) begin
                runlen[c] = runlen[c] + 1;
            end else begin
                if (prev[c]) last_hi[c] = runlen[c];
                else begin
                    last_lo[c] = runlen[c];
                    rises[c]   = rises[c] + 1;
                end
                runlen[c] = 1;
                prev[c]   = pwm_out[c];
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bw(input int ch, input logic [4:0] off, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = AW'(ch * 32 + int'(off));
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic br(input int ch, input logic [4:0] off, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1;
        bus_addr  = AW'(ch * 32 + int'(off));
        @(posedge clk);
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_wave(input int ch, input int s, input int m, input int d);
        bw(ch, O_MOD, 32'(m));
        bw(ch, O_DUTY, 32'(d));
        bw(ch, O_SCALE, 32'(s));
    endtask

    task automatic wait_rises(input int ch, input int n);
        int tgt;
        tgt = rises[ch] + n;
        while (rises[ch] < tgt) @(posedge clk);
    endtask

    task automatic count_high(input int ch, input int cycles, output int highs);
        highs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) highs++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        check("R10 outputs low after reset", int'(pwm_out), 0);
        br(0, O_SCALE, v); check("R10 prescale reads zero", int'(v), 0);
        br(3, O_RUN, v);   check("R10 enable reads zero", int'(v), 0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        bw(1, O_MOD, 32'h0000_01FF);
        br(1, O_MOD, v);  check("R2 modulus keeps 8 bits", int'(v), 'hFF);
        bw(2, O_DUTY, 32'hABCD_1234);
        br(2, O_DUTY, v); check("R2 duty keeps 16 bits", int'(v), 'h1234);
        bw(2, O_DIV, 32'h0001_00C3);
        br(2, O_DIV, v);  check("R2 divider keeps 16 bits", int'(v), 'hC3);
        bw(2, O_PATL, 32'h0000_5A5A);
        bw(2, O_PATH, 32'hFFFF_A5A5);
        br(2, O_PATL, v); check("R1 pattern low readback", int'(v), 'h5A5A);
        br(2, O_PATH, v); check("R2 pattern high keeps 16 bits", int'(v), 'hA5A5);
        br(0, O_MOD, v);  check("R1 other bank untouched", int'(v), 0);
        br(1, O_DUTY, v); check("R1 bank 1 duty separate from bank 2", int'(v), 0);
        bw(1, O_HOLE, 32'hFFFF_FFFF);
        br(1, O_HOLE, v); check("R3 unmapped offset reads zero", int'(v), 0);
        br(1, 5'h05, v);  check("R3 unaligned offset reads zero", int'(v), 0);
        br(1, O_MOD, v);  check("R3 write to unmapped left modulus", int'(v), 'hFF);
        br(1, O_RUN, v);  check("R3 write to unmapped left enable", int'(v), 0);
    endtask

    task automatic t_waves();
        set_wave(0, 0, 10, 3);
        set_wave(1, 2, 8, 5);
        set_wave(2, 4, 5, 1);
        set_wave(3, 1, 255, 100);
        repeat (3) @(posedge clk);
        for (int c = 0; c < NCH; c++) bw(c, O_RUN, 32'h1);
        wait_rises(0, 3);
        check("R4 R11 ch0 high", last_hi[0], 3);
        check("R4 R11 ch0 low",  last_lo[0], 7);
        wait_rises(1, 3);
        check("R4 R11 ch1 high", last_hi[1], 15);
        check("R4 R11 ch1 low",  last_lo[1], 9);
        wait_rises(2, 3);
        check("R4 R11 ch2 high", last_hi[2], 5);
        check("R4 R11 ch2 low",  last_lo[2], 20);
        wait_rises(3, 3);
        check("R4 R11 ch3 high", last_hi[3], 200);
        check("R4 R11 ch3 low",  last_lo[3], 310);
    endtask

    task automatic t_update();
        wait_rises(1, 1);
        bw(1, O_MOD, 32'd6);
        bw(1, O_DUTY, 32'd2);
        wait_rises(1, 2);
        check("R5 shadow writes keep high", last_hi[1], 15);
        check("R5 shadow writes keep low",  last_lo[1], 9);
        wait_rises(1, 1);
        bw(1, O_SCALE, 32'd1);
        wait_rises(1, 1);
        check("R6 period in progress high unchanged", last_hi[1], 15);
        check("R6 period in progress low unchanged",  last_lo[1], 9);
        wait_rises(1, 1);
        check("R6 next period high new", last_hi[1], 4);
        check("R6 next period low new",  last_lo[1], 8);
    endtask

    task automatic t_mod_zero();
        int h;
        set_wave(2, 0, 0, 5);
        repeat (60) @(posedge clk);
        count_high(2, 100, h);
        check("R7 zero modulus holds low", h, 0);
    endtask

    task automatic t_full();
        int h;
        set_wave(3, 0, 4, 4);
        repeat (600) @(posedge clk);
        count_high(3, 100, h);
        check("R8 duty equal to modulus holds high", h, 100);
        set_wave(3, 0, 4, 9);
        repeat (20) @(posedge clk);
        count_high(3, 100, h);
        check("R8 duty above modulus holds high", h, 100);
    endtask

    task automatic t_enable();
        int h;
        wait_rises(1, 1);
        bw(1, O_RUN, 32'h0);
        check("R9 output low right after disable", int'(pwm_out[1]), 0);
        count_high(1, 40, h);
        check("R9 output stays low while disabled", h, 0);
        bw(1, O_RUN, 32'h1);
        check("R9 fresh period starts high", int'(pwm_out[1]), 1);
        h = 1;
        @(negedge clk);
        while (pwm_out[1] && h < 100) begin
            h++;
            @(negedge clk);
        end
        check("R9 first high phase is full length", h, 4);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_waves();
        t_update();
        t_mod_zero();
        t_full();
        t_enable();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule